// File: doc/BRIEF.md
# Triggered Strip Hit Latch and Event Packer

This block sits behind the discriminators of one detector plane pair and turns a trigger into a fixed-format event record. It watches 128 strip lines, 64 for the X plane followed by 64 for the Y plane. A two-flop synchronizer brings each line into the clock domain. While the block waits for a trigger, an acquisition window is open. During the window it marks every strip that has been seen high. It also forms 16 timing channels, each the OR of eight neighbouring strips. For each channel it stamps both the leading and the trailing edges with a local 16-bit window counter, keeping up to four stamps per edge direction.

When a trigger pulse arrives in the window, the block freezes the pattern and the edge stamps. It latches the 64-bit timestamp and the 32-bit board identifier, and it advances the event number. It then streams a 2304-bit record as 72 words of 32 bits over a valid/ready handshake and marks the final word with last. When that final word is accepted, the storage is wiped, the window counter restarts from zero and a new window opens. A trigger that arrives while a record is still being sent is dropped and sets a sticky overflow flag.

Top module: `strip_hit_packer`

## Requirements
- R1: A trigger sampled while the window is open makes `outValid` rise on the next cycle. The record is exactly 72 accepted words. `outLast` is high only with the 72nd word, and `outValid` is low on the cycle after that word is accepted.
- R2: Words 0 to 63 carry the edge stamps. Word `4c+k` holds leading-edge stamps `2k` (bits 15:0) and `2k+1` (bits 31:16) of channel c for k = 0 and 1. Word `4c+2+k` holds the trailing-edge stamps with the same layout.
- R3: Words 64 to 67 carry the hit pattern, with strip `i` at bit `i mod 32` of word `64 + i/32`. A bit is set when its strip was seen high at any time in the window up to the trigger.
- R4: Word 68 is the board identifier, word 70 is timestamp bits 31:0 and word 71 is bits 63:32. All of them are latched in the trigger cycle.
- R5: Word 69 is the event number. It is 1 in the first record after reset and rises by one for each accepted trigger only.
- R6: A trigger that arrives while a record is being sent is dropped: no new record follows and the event number does not change. `overflow` goes high the next cycle and stays high until reset.
- R7: Timing channel c is the OR of strips 8c to 8c+7. A second strip of the same channel rising while the channel is already high adds no stamp, and strips of other channels leave channel c empty.
- R8: Stamps come from a counter that restarts at zero when a window opens and advances once per cycle. The trailing stamp minus the leading stamp of a pulse equals its width in cycles.
- R9: Only the first four edges of each direction per channel are kept. Further edges are discarded, and slots with no edge read zero.
- R10: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays unchanged.
- R11: After reset, `outValid`, `outLast` and `overflow` are low.
- R12: A record from a window with no strip activity has all stamp and hit words zero, even when it directly follows a busy record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stripIn | input | 128 | Discriminated strip levels, X plane in bits 63:0, Y plane in bits 127:64 |
| trigIn | input | 1 | Trigger pulse |
| tsIn | input | 64 | Free-running timestamp |
| boardId | input | 32 | Board identifier |
| outReady | input | 1 | Downstream can take a word |
| outData | output | 32 | Record word |
| outValid | output | 1 | `outData` holds a record word |
| outLast | output | 1 | Final word of the record |
| overflow | output | 1 | Sticky flag for a dropped trigger |

## Verification
The first word of a record is on the port one cycle after the clock edge that samples the trigger. Each later word follows one cycle after the previous one is accepted. A strip change reaches the edge stamps three edges after it is driven: two synchronizer stages plus the comparison against the previous channel level. The bench therefore leaves four idle cycles between the last strip change and the trigger. It checks stamp differences (pulse width, pulse spacing) rather than absolute stamps, so this fixed latency cancels out. All samples are taken on the falling clock edge, and the stall and dropped-trigger checks are placed at known word indices of a running record.

// File: rtl/shp_pkg.sv
package shp_pkg;
  parameter int STRIPS = 128;
  parameter int GROUP  = 8;
  parameter int HITS   = 4;
  parameter int TW     = 16;
  parameter int WW     = 32;
  parameter int TSW    = 64;
  parameter int IDW    = 32;
  parameter int EVW    = 32;

  localparam int CHANS      = STRIPS / GROUP;
  localparam int TIME_BITS  = CHANS * 2 * HITS * TW;
  localparam int TIME_WORDS = TIME_BITS / WW;
  localparam int HIT_WORDS  = STRIPS / WW;
  localparam int REC_BITS   = TIME_BITS + STRIPS + IDW + EVW + TSW;
  localparam int REC_WORDS  = REC_BITS / WW;
  localparam int IDXW       = $clog2(REC_WORDS);
  localparam int HCW        = $clog2(HITS + 1);
  localparam int HIW        = $clog2(HITS);

  typedef struct packed {
    logic            acqEn;
    logic            capture;
    logic            clearWin;
    logic [IDXW-1:0] wordIdx;
  } ctrl_t;
endpackage

// File: rtl/shp_datapath.sv
module shp_datapath
  import shp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STRIPS-1:0] stripIn,
  input  logic [TSW-1:0]    tsIn,
  input  logic [IDW-1:0]    boardId,
  input  logic [EVW-1:0]    eventNum,
  input  ctrl_t             ctl,
  output logic [WW-1:0]     wordOut
);
  logic [STRIPS-1:0]    syncA, syncB, hitPat;
  logic [CHANS-1:0]     chanNow, chanPrev;
  logic [TW-1:0]        timer;
  logic [TSW-1:0]       tsLat;
  logic [IDW-1:0]       idLat;
  logic [TIME_BITS-1:0] timeFlat;
  logic [REC_BITS-1:0]  recFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      chanPrev <= '0;
    end else begin
      syncA    <= stripIn;
      syncB    <= syncA;
      chanPrev <= chanNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer  <= '0;
      hitPat <= '0;
    end else if (ctl.clearWin) begin
      timer  <= '0;
      hitPat <= '0;
    end else if (ctl.acqEn) begin
      timer  <= timer + 1'b1;
      hitPat <= hitPat | syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsLat <= '0;
      idLat <= '0;
    end else if (ctl.capture) begin
      tsLat <= tsIn;
      idLat <= boardId;
    end
  end

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    logic [TW-1:0]  riseT [HITS];
    logic [TW-1:0]  fallT [HITS];
    logic [HCW-1:0] riseN, fallN;
    logic           isRise, isFall;

    assign chanNow[c] = |syncB[c*GROUP +: GROUP];
    assign isRise     = chanNow[c] && !chanPrev[c];
    assign isFall     = !chanNow[c] && chanPrev[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        riseN <= '0;
        fallN <= '0;
        for (int h = 0; h < HITS; h++) begin
          riseT[h] <= '0;
          fallT[h] <= '0;
        end
      end else if (ctl.clearWin) begin
        riseN <= '0;
        fallN <= '0;
        for (int h = 0; h < HITS; h++) begin
          riseT[h] <= '0;
          fallT[h] <= '0;
        end
      end else if (ctl.acqEn) begin
        if (isRise && (riseN < HCW'(HITS))) begin
          riseT[riseN[HIW-1:0]] <= timer;
          riseN                 <= riseN + 1'b1;
        end
        if (isFall && (fallN < HCW'(HITS))) begin
          fallT[fallN[HIW-1:0]] <= timer;
          fallN                 <= fallN + 1'b1;
        end
      end
    end

    for (genvar h = 0; h < HITS; h++) begin : g_slot
      assign timeFlat[(c*2*HITS + h)*TW +: TW]        = riseT[h];
      assign timeFlat[(c*2*HITS + HITS + h)*TW +: TW] = fallT[h];
    end
  end

  assign recFlat = {tsLat, eventNum, idLat, hitPat, timeFlat};
  assign wordOut = recFlat[int'(ctl.wordIdx)*WW +: WW];
endmodule

// File: rtl/shp_control.sv
module shp_control
  import shp_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           trigIn,
  input  logic           outReady,
  output ctrl_t          ctl,
  output logic           outValid,
  output logic           outLast,
  output logic           overflow,
  output logic [EVW-1:0] eventNum
);
  logic            sending;
  logic [IDXW-1:0] idx;
  logic            fire, lastWord;

  assign fire     = sending && outReady;
  assign lastWord = (idx == IDXW'(REC_WORDS - 1));

  always_comb begin
    ctl.acqEn    = !sending;
    ctl.capture  = !sending && trigIn;
    ctl.clearWin = fire && lastWord;
    ctl.wordIdx  = idx;
  end

  assign outValid = sending;
  assign outLast  = sending && lastWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sending  <= 1'b0;
      idx      <= '0;
      eventNum <= '0;
      overflow <= 1'b0;
    end else begin
      if (ctl.capture) begin
        sending  <= 1'b1;
        eventNum <= eventNum + 1'b1;
      end
      if (fire) begin
        if (lastWord) begin
          sending <= 1'b0;
          idx     <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (sending && trigIn) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/strip_hit_packer.sv
module strip_hit_packer
  import shp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STRIPS-1:0] stripIn,
  input  logic              trigIn,
  input  logic [TSW-1:0]    tsIn,
  input  logic [IDW-1:0]    boardId,
  input  logic              outReady,
  output logic [WW-1:0]     outData,
  output logic              outValid,
  output logic              outLast,
  output logic              overflow
);
  ctrl_t          ctl;
  logic [EVW-1:0] eventNum;

  shp_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trigIn   (trigIn),
    .outReady (outReady),
    .ctl      (ctl),
    .outValid (outValid),
    .outLast  (outLast),
    .overflow (overflow),
    .eventNum (eventNum)
  );

  shp_datapath u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stripIn  (stripIn),
    .tsIn     (tsIn),
    .boardId  (boardId),
    .eventNum (eventNum),
    .ctl      (ctl),
    .wordOut  (outData)
  );
endmodule

// File: rtl/strip_hit_packer_chk.sv
module strip_hit_packer_chk
  import shp_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          trigIn,
  input logic          outReady,
  input logic [WW-1:0] outData,
  input logic          outValid,
  input logic          outLast,
  input logic          overflow
);
  logic [IDXW-1:0] beatCnt;
  logic            beat;

  assign beat = outValid && outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        beatCnt <= '0;
    else if (beat)    beatCnt <= outLast ? '0 : beatCnt + 1'b1;
  end

  AST_LAST_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (beat && outLast) |-> (beatCnt == IDXW'(REC_WORDS - 1))); // R1
  AST_FULL_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    (beat && beatCnt == IDXW'(REC_WORDS - 1)) |-> outLast); // R1
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R1
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && trigIn) |=> outValid); // R1
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (beat && outLast) |=> !outValid); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R10
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && trigIn) |=> overflow); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R6
endmodule

bind strip_hit_packer strip_hit_packer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .trigIn   (trigIn),
  .outReady (outReady),
  .outData  (outData),
  .outValid (outValid),
  .outLast  (outLast),
  .overflow (overflow)
);

// File: tb/strip_hit_packer_bench.sv
module strip_hit_packer_bench;
  import shp_pkg::*;

  logic              clk = 1'b0;
  logic              rstN;
  logic [STRIPS-1:0] stripIn;
  logic              trigIn;
  logic [TSW-1:0]    tsIn;
  logic [IDW-1:0]    boardId;
  logic              outReady;
  logic [WW-1:0]     outData;
  logic              outValid, outLast, overflow;

  always #4 clk = ~clk;

  strip_hit_packer u_strip_hit_packer (
    .clk(clk), .rstN(rstN), .stripIn(stripIn), .trigIn(trigIn), .tsIn(tsIn),
    .boardId(boardId), .outReady(outReady), .outData(outData),
    .outValid(outValid), .outLast(outLast), .overflow(overflow)
  );

  // strip[16:10], width[9:4], pulse count[3:0]
  localparam logic [16:0] VEC [6] = '{
    {7'd0,   6'd3,  4'd1},
    {7'd13,  6'd4,  4'd2},
    {7'd63,  6'd2,  4'd4},
    {7'd64,  6'd6,  4'd3},
    {7'd100, 6'd1,  4'd5},
    {7'd127, 6'd10, 4'd6}
  };
  localparam int GAP = 5;

  int          nChk = 0, nFail = 0;
  logic [31:0] rec [72];
  logic [31:0] evExp = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] getT(input int c, input int dir, input int h);
    logic [31:0] w;
    w = rec[c*4 + dir*2 + h/2];
    return (h % 2) ? w[31:16] : w[15:0];
  endfunction

  task automatic pulse(input int s, input int w);
    stripIn[s] = 1'b1;
    repeat (w) @(negedge clk);
    stripIn[s] = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic trig(input logic [63:0] ts);
    trigIn = 1'b1;
    tsIn   = ts;
    @(negedge clk);
    trigIn = 1'b0;
  endtask

  task automatic collect(input int stallAt, input int trigAt);
    int lastCnt = 0;
    logic [31:0] hold;
    for (int i = 0; i < 72; i++) begin
      int t = 0;
      while (!outValid && t < 100) begin @(negedge clk); t++; end
      if (i == stallAt) begin
        outReady = 1'b0;
        hold = outData;
        repeat (5) begin
          @(negedge clk);
          chk(outValid && outData == hold, "R10", "stall hold", {31'd0, outValid, outData}, {32'd1, hold});
        end
        outReady = 1'b1;
      end
      if (i == trigAt) trigIn = 1'b1;
      rec[i] = outData;
      if (outLast) begin
        lastCnt++;
        chk(i == 71, "R1", "last position", i, 71);
      end
      @(negedge clk);
      trigIn = 1'b0;
    end
    chk(lastCnt == 1, "R1", "last count", lastCnt, 1);
    chk(!outValid, "R1", "idle after last", outValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [127:0] hexp;
    logic [63:0]  ts;
    int strip, wid, cnt, c, kept;
    bit okOther;

    rstN = 0; stripIn = '0; trigIn = 0; tsIn = '0; boardId = 32'hB0A2_D017; outReady = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!outValid && !outLast && !overflow, "R11", "reset outputs",
        {outValid, outLast, overflow}, 0);

    // table walk: R2 R3 R4 R5 R7 R8 R9
    for (int e = 0; e < 6; e++) begin
      strip = int'(VEC[e][16:10]);
      wid   = int'(VEC[e][9:4]);
      cnt   = int'(VEC[e][3:0]);
      c     = strip / GROUP;
      kept  = (cnt < HITS) ? cnt : HITS;
      repeat (4) @(negedge clk);
      for (int k = 0; k < cnt; k++) pulse(strip, wid);
      repeat (4) @(negedge clk);
      ts = {32'hA5A5_0000 + e, 32'h1234_0000 + e};
      trig(ts);
      collect(-1, -1);
      evExp++;
      for (int h = 0; h < HITS; h++) begin
        if (h < kept) begin
          chk(getT(c, 1, h) - getT(c, 0, h) == wid[15:0], "R8", "pulse width",
              getT(c, 1, h) - getT(c, 0, h), wid);
          chk(getT(c, 0, h) != 0, "R2", "stamp present", getT(c, 0, h), 1);
          if (h > 0)
            chk(getT(c, 0, h) - getT(c, 0, h-1) == 16'(wid + GAP), "R8", "pulse spacing",
                getT(c, 0, h) - getT(c, 0, h-1), wid + GAP);
        end else begin
          chk(getT(c, 0, h) == 0 && getT(c, 1, h) == 0, "R9", "unused slot zero",
              {getT(c, 0, h), getT(c, 1, h)}, 0);
        end
      end
      okOther = 1;
      for (int cc = 0; cc < CHANS; cc++)
        if (cc != c)
          for (int w = 0; w < 4; w++) if (rec[cc*4 + w] != 0) okOther = 0;
      chk(okOther, "R7", "other channels empty", okOther, 1);
      hexp = 128'd1 << strip;
      chk({rec[67], rec[66], rec[65], rec[64]} == hexp, "R3", "hit pattern",
          {rec[65], rec[64]}, hexp[63:0]);
      chk(rec[68] == boardId, "R4", "board id", rec[68], boardId);
      chk(rec[69] == evExp, "R5", "event number", rec[69], evExp);
      chk({rec[71], rec[70]} == ts, "R4", "timestamp", {rec[71], rec[70]}, ts);
    end

    // R12: quiet window right after a busy one
    repeat (4) @(negedge clk);
    trig(64'h1);
    collect(-1, -1);
    evExp++;
    okOther = 1;
    for (int w = 0; w < 68; w++) if (rec[w] != 0) okOther = 0;
    chk(okOther, "R12", "quiet record zero", okOther, 1);

    // R7: two strips of one channel overlap; stall mid-record (R10)
    repeat (4) @(negedge clk);
    stripIn[16] = 1; repeat (2) @(negedge clk);
    stripIn[19] = 1; repeat (3) @(negedge clk);
    stripIn[16] = 0; repeat (2) @(negedge clk);
    stripIn[19] = 0; repeat (4) @(negedge clk);
    trig(64'h2);
    collect(10, -1);
    evExp++;
    chk(getT(2, 0, 0) != 0 && getT(2, 0, 1) == 0, "R7", "single merged rise",
        {getT(2, 0, 0), getT(2, 0, 1)}, 0);
    chk(getT(2, 1, 0) - getT(2, 0, 0) == 16'd7, "R7", "merged span",
        getT(2, 1, 0) - getT(2, 0, 0), 7);
    chk(rec[64] == 32'h0009_0000, "R3", "two strips hit", rec[64], 32'h0009_0000);

    // R6: trigger during a record is dropped
    chk(!overflow, "R6", "overflow clear before", overflow, 0);
    repeat (4) @(negedge clk);
    trig(64'h3);
    collect(-1, 5);
    evExp++;
    chk(overflow, "R6", "overflow set", overflow, 1);
    repeat (3) @(negedge clk);
    chk(!outValid, "R6", "no record from dropped trigger", outValid, 0);
    trig(64'h4);
    collect(-1, -1);
    evExp++;
    chk(rec[69] == evExp, "R5", "event number after drop", rec[69], evExp);
    chk(overflow, "R6", "overflow sticky", overflow, 1);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule